// File: doc/BRIEF.md
# Expansion Slot Response Collision Guard

This block sits beside a shared expansion bus that serves several plug-in slots. Each slot has its own active-low response line. A card pulls its line low when it decodes the current bus address as its own. The host side also supplies a flag that marks an address as owned by the local bus. In every strobed bus cycle the guard waits a fixed number of clocks so that slow response lines can settle. It then judges whether the responses conflict: either more than one slot answered, or any slot answered an address the local bus keeps for itself.

On a conflict the guard pulls the shared bus-error line low. That line is open-drain, so the block only reports "sink" or "release". The guard also produces the data-buffer enable. For a read, the enable stays off until the judgement is made, so two cards can never drive the data lines against each other. A read that collided never gets its enable. For a write, the enable comes on as soon as the strobe is seen, because the master drives the data lines. Everything returns to rest once the strobe is seen inactive again.

Top module: `slot_collision_guard`

## Requirements
- R1: While reset is asserted and on leaving it, `berr_pull` is 0 (the line is released) and `data_oe` is 0.
- R2: A bus cycle starts at the first rising edge at which `as_n` is sampled 0 after being sampled 1. The response judgement is made from `slave_n` and `local_rsv` as sampled at the SETTLE_CYC-th rising edge after that start edge (default 2). Its effect on `berr_pull` and on a read's `data_oe` appears at that same edge.
- R3: If two or more bits of `slave_n` are 0 at the judgement edge, `berr_pull` becomes 1.
- R4: If `local_rsv` is 1 and at least one bit of `slave_n` is 0 at the judgement edge, `berr_pull` becomes 1.
- R5: If no slave bit is 0, or exactly one is 0 while `local_rsv` is 0, `berr_pull` stays 0.
- R6: In a read cycle (`rd`=1 at the start edge), `data_oe` is 0 from the start edge until the judgement edge. It becomes 1 at the judgement edge when no conflict was found.
- R7: In a read cycle with a conflict, `data_oe` stays 0 for the whole cycle.
- R8: In a write cycle (`rd`=0 at the start edge), `data_oe` becomes 1 at the start edge, whatever the slave lines do.
- R9: After the judgement edge, `berr_pull` and `data_oe` hold while `as_n` stays 0. Later changes on `slave_n` or `local_rsv` have no effect.
- R10: At any rising edge with `as_n` sampled 1, both outputs go to 0. Slave and reserved activity while the strobe is inactive has no effect.
- R11: The cycle direction is captured at the start edge. A later change of `rd` within the same cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-synchronous clock |
| rst_n | input | 1 | Active-low synchronous reset |
| as_n | input | 1 | Active-low address strobe |
| rd | input | 1 | Cycle direction, 1 = read, 0 = write |
| slave_n | input | NSLOT | Per-slot response lines, 0 = slot responding |
| local_rsv | input | 1 | 1 = current address belongs to the local bus |
| berr_pull | output | 1 | 1 = sink the open-drain bus-error line, 0 = release |
| data_oe | output | 1 | Data-buffer enable, 1 = enabled |

## Verification
The hardest state to reach is after the judgement, with the strobe still held. Only there can the bench show that late slave or reserved-flag changes, and a flipped direction, are ignored. Each directed cycle therefore holds the strobe past the judgement edge and then deliberately disturbs every input. The outputs are checked again before the strobe is released. Read cycles are also sampled in the clocks just before the judgement edge, which proves that the enable is withheld for the full settling window.

// File: rtl/scg_pkg.sv
package scg_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_HELD   = 2'd2
    } scg_phase_e;

endpackage

// File: rtl/scg_window.sv
module scg_window
    import scg_pkg::*;
#(
    parameter int SETTLE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic as_n,
    output logic start,
    output logic eval
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        scg_phase_e       phase;
        logic [CNT_W-1:0] cnt;
    } win_t;

    win_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        start = 1'b0;
        eval  = 1'b0;
        if (as_n) begin
            nxt_d.phase = PH_IDLE;
            nxt_d.cnt   = '0;
        end else begin
            case (cur_q.phase)
                PH_IDLE: begin
                    start       = 1'b1;
                    nxt_d.phase = PH_SETTLE;
                    nxt_d.cnt   = CNT_W'(1);
                end
                PH_SETTLE: begin
                    if (cur_q.cnt == CNT_W'(SETTLE_CYC)) begin
                        eval        = 1'b1;
                        nxt_d.phase = PH_HELD;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                default: nxt_d = cur_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.phase <= PH_IDLE;
            cur_q.cnt   <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase == PH_IDLE) |-> (cur_q.cnt == '0)); // R2
    AST_NO_START_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && eval)); // R2

endmodule

// File: rtl/scg_judge.sv
module scg_judge #(
    parameter int NSLOT = 5
) (
    input  logic [NSLOT-1:0] slave_n,
    input  logic             local_rsv,
    output logic             hit
);
    localparam int NUM_W = $clog2(NSLOT + 1);

    logic [NSLOT-1:0] act;
    logic [NUM_W-1:0] num;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign act[s] = ~slave_n[s];
    end

    always_comb begin
        num = '0;
        for (int s = 0; s < NSLOT; s++) begin
            num = num + NUM_W'(act[s]);
        end
    end

    assign hit = (num > NUM_W'(1)) || (local_rsv && (num != '0));

endmodule

// File: rtl/slot_collision_guard.sv
module slot_collision_guard #(
    parameter int NSLOT      = 5,
    parameter int SETTLE_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             as_n,
    input  logic             rd,
    input  logic [NSLOT-1:0] slave_n,
    input  logic             local_rsv,
    output logic             berr_pull,
    output logic             data_oe
);
    typedef struct packed {
        logic berr;
        logic doe;
        logic rd;
    } out_t;

    out_t cur_q, nxt_d;
    logic start, eval, hit;

    scg_window #(.SETTLE_CYC(SETTLE_CYC)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .as_n  (as_n),
        .start (start),
        .eval  (eval)
    );

    scg_judge #(.NSLOT(NSLOT)) u_judge (
        .slave_n   (slave_n),
        .local_rsv (local_rsv),
        .hit       (hit)
    );

    always_comb begin
        nxt_d = cur_q;
        if (as_n) begin
            nxt_d.berr = 1'b0;
            nxt_d.doe  = 1'b0;
        end else if (start) begin
            nxt_d.rd   = rd;
            nxt_d.doe  = !rd;
            nxt_d.berr = 1'b0;
        end else if (eval) begin
            nxt_d.berr = hit;
            if (cur_q.rd) nxt_d.doe = !hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign berr_pull = cur_q.berr;
    assign data_oe   = cur_q.doe;

    AST_RELEASE_ON_NEGATE: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> (!berr_pull && !data_oe)); // R10
    AST_READ_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (start && rd) |=> !data_oe); // R6
    AST_WRITE_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !rd) |=> data_oe); // R8
    AST_MULTI_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && ($countones(~slave_n) > 1)) |=> berr_pull); // R3
    AST_RSV_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && local_rsv && ($countones(~slave_n) > 0)) |=> berr_pull); // R4
    AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && ($countones(~slave_n) <= 1) &&
         !(local_rsv && ($countones(~slave_n) == 1))) |=> !berr_pull); // R5
    AST_READ_COLL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (berr_pull && cur_q.rd) |-> !data_oe); // R7
    AST_HOLD_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && !start && !eval) |=> ($stable(berr_pull) && $stable(data_oe))); // R9

endmodule

// File: tb/slot_collision_guard_bench.sv
module slot_collision_guard_bench;
    localparam int NSLOT = 5;
    localparam int SETTLE_CYC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic as_n = 1'b1;
    logic rd = 1'b0;
    logic [NSLOT-1:0] slave_n = '1;
    logic local_rsv = 1'b0;
    logic berr_pull, data_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    slot_collision_guard #(.NSLOT(NSLOT), .SETTLE_CYC(SETTLE_CYC)) u_slot_collision_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_n      (as_n),
        .rd        (rd),
        .slave_n   (slave_n),
        .local_rsv (local_rsv),
        .berr_pull (berr_pull),
        .data_oe   (data_oe)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One full strobed cycle; all samples taken at falling edges.
    task automatic do_cycle(input string name, input logic r, input logic [NSLOT-1:0] sl,
                            input logic rsv, input logic coll, input logic flip_rd);
        as_n = 1'b0; rd = r; slave_n = sl; local_rsv = rsv;
        step(1); // start edge has passed
        chk({name, " R8/R6 enable at start"}, data_oe, !r);
        chk({name, " R2 no early error"}, berr_pull, 1'b0);
        if (flip_rd) rd = !r; // R11
        for (int i = 1; i < SETTLE_CYC; i++) begin
            step(1);
            chk({name, " R6 window enable"}, data_oe, !r);
            chk({name, " R2 window error"}, berr_pull, 1'b0);
        end
        step(1); // judgement edge has passed
        chk({name, " R3/R4/R5 error"}, berr_pull, coll);
        chk({name, " R6/R7/R8/R11 enable"}, data_oe, r ? !coll : 1'b1);
        slave_n = ~sl; local_rsv = !rsv; rd = !rd; // R9 disturbance
        step(2);
        chk({name, " R9 error held"}, berr_pull, coll);
        chk({name, " R9 enable held"}, data_oe, r ? !coll : 1'b1);
        as_n = 1'b1; slave_n = '1; local_rsv = 1'b0;
        step(1);
        chk({name, " R10 error released"}, berr_pull, 1'b0);
        chk({name, " R10 enable off"}, data_oe, 1'b0);
    endtask

    task automatic test_reset();
        as_n = 1'b0; slave_n = 5'b00000; local_rsv = 1'b1; rd = 1'b1;
        rst_n = 1'b0;
        step(3);
        chk("R1 reset error", berr_pull, 1'b0);
        chk("R1 reset enable", data_oe, 1'b0);
        as_n = 1'b1; slave_n = '1; local_rsv = 1'b0;
        rst_n = 1'b1;
        step(1);
        chk("R1 after reset error", berr_pull, 1'b0);
        chk("R1 after reset enable", data_oe, 1'b0);
    endtask

    task automatic test_idle_ignore();
        as_n = 1'b1; slave_n = 5'b00000; local_rsv = 1'b1; rd = 1'b1;
        step(3);
        chk("R10 idle error", berr_pull, 1'b0);
        chk("R10 idle enable", data_oe, 1'b0);
        slave_n = '1; local_rsv = 1'b0;
        step(1);
    endtask

    initial begin
        test_reset();
        test_idle_ignore();
        do_cycle("read single R5",      1'b1, 5'b11101, 1'b0, 1'b0, 1'b0);
        do_cycle("read none R5",        1'b1, 5'b11111, 1'b0, 1'b0, 1'b0);
        do_cycle("read rsv none R5",    1'b1, 5'b11111, 1'b1, 1'b0, 1'b0);
        do_cycle("read two R3",         1'b1, 5'b01110, 1'b0, 1'b1, 1'b0);
        do_cycle("read all R3",         1'b1, 5'b00000, 1'b0, 1'b1, 1'b0);
        do_cycle("read rsv one R4",     1'b1, 5'b10111, 1'b1, 1'b1, 1'b0);
        do_cycle("write single R8",     1'b0, 5'b11110, 1'b0, 1'b0, 1'b0);
        do_cycle("write coll R8",       1'b0, 5'b00111, 1'b0, 1'b1, 1'b0);
        do_cycle("write rsv R4",        1'b0, 5'b01111, 1'b1, 1'b1, 1'b0);
        do_cycle("read flip R11",       1'b1, 5'b11011, 1'b0, 1'b0, 1'b1);
        do_cycle("write flip R11",      1'b0, 5'b11011, 1'b0, 1'b0, 1'b1);
        do_cycle("read coll again R7",  1'b1, 5'b11100, 1'b0, 1'b1, 1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule